// File: doc/BRIEF.md
# Prioritized vectored interrupt controller

This block gathers interrupt requests from a bank of maskable peripheral lines and from the system exception sources of a processor core. Every cycle it picks the most urgent enabled pending request and presents that request's exception number and its vector fetch address to the core. The core then fetches the handler address from that vector address.

Peripheral line `n` is exception number `16+n`. Exception numbers 1 to 15 belong to the system. Three system exceptions have fixed urgencies that beat every programmable level. These are reset (1), the non-maskable interrupt (2) and the catch-all fault (3). Memory-management fault (4), bus fault (5), usage fault (6), supervisor call (11), debug monitor (12) and the pendable service request (14) take programmable 4-bit priorities. The remaining system numbers are reserved.

Software uses a one-cycle configuration strobe to program enables, pending bits and priorities. The core reports handler entry through an acknowledge and handler exit through a return strobe. The block tracks which exceptions are active and offers a request only when that request would preempt the most urgent active handler.

Top module: `vect_irq_ctrl`

## Requirements
- R1: After reset no request is offered (`exc_req`=0, `exc_num`=0, `exc_addr`=0). No pending or active bit is set, every peripheral enable is off and every programmable priority is 0.
- R2: The offered address is always four times the offered exception number. Peripheral line n is offered as number 16+n, and system numbers 1 to 6, 11, 12 and 14 are offered under their own number.
- R3: Numbers 0, 7, 8, 9, 10, 13 and 15, and numbers at or above 16+NUM_IRQ, are never offered. A pulse or a pend-set to them leaves no request.
- R4: Reset (1) outranks the NMI (2), the NMI outranks the fault (3), and the fault outranks every programmable level. Priority writes to numbers 1 to 3 are ignored.
- R5: Among programmable sources, a lower 4-bit priority value wins. This holds across system and peripheral sources alike.
- R6: When two candidates have equal priority, the lower exception number wins.
- R7: A candidate is offered only when no exception is active, or when its urgency is strictly higher than that of the most urgent active exception. An equal or lower candidate stays pending.
- R8: An acknowledge of number k sets k active and clears k's pending bit on the same clock edge.
- R9: A return strobe for number k clears k's active bit, which releases the candidates it was blocking.
- R10: A disabled peripheral line is not arbitrated, but its pending bit is kept, and enabling it again offers the request.
- R11: System exceptions, including the NMI, have no enable. An enable-clear addressed to them has no effect.
- R12: A pending bit is set by a request pulse (`irq_pulse`, `sys_pulse`) or by a configuration write with `cfg_op`=2. It is cleared by `cfg_op`=3. `cfg_op`=0 sets the enable, `cfg_op`=1 clears it, `cfg_op`=4 writes `cfg_prio`, and any other code does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_pulse | input | NUM_IRQ (43) | One-cycle request pulses of the peripheral lines |
| sys_pulse | input | 16 | One-cycle request pulses indexed by system exception number |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 3 | Configuration operation code |
| cfg_num | input | NUM_W (6) | Exception number the write addresses |
| cfg_prio | input | PRIO_W (4) | Priority value for a priority write |
| ack_i | input | 1 | Core entered the handler of `ack_num` |
| ack_num | input | NUM_W (6) | Exception number being entered |
| ret_i | input | 1 | Core left the handler of `ret_num` |
| ret_num | input | NUM_W (6) | Exception number being left |
| exc_req | output | 1 | A preempting exception is offered |
| exc_num | output | NUM_W (6) | Offered exception number, 0 when idle |
| exc_addr | output | ADDR_W (32) | Vector fetch address, 0 when idle |

## Verification
Each of the sixteen system numbers and each peripheral line is pended alone. This tells implemented slots from reserved ones, checks the number-to-address mapping, and checks that acknowledge and return leave nothing behind. Two peripheral lines are then swept over all 256 priority pairs. That sweep separates the value comparison from the tie rule on exception number. Stacked fixed-priority requests, a nested preemption sequence with equal and strictly more urgent arrivals, and disable, re-enable and pend-clear cycles cover the ordering of the fixed exceptions, the strict preemption threshold and the retention of pending bits.

// File: rtl/virq_pkg.sv
package virq_pkg;

  localparam int SYS_LINES = 16;

  typedef enum logic [2:0] {
    OP_EN_SET   = 3'd0,
    OP_EN_CLR   = 3'd1,
    OP_PEND_SET = 3'd2,
    OP_PEND_CLR = 3'd3,
    OP_PRIO     = 3'd4
  } cfg_op_e;

  // System slots that carry a handler; all others below 16 are reserved.
  function automatic bit sys_slot_used(int n);
    return n inside {1, 2, 3, 4, 5, 6, 11, 12, 14};
  endfunction

  // Slots whose urgency is hard-wired above every programmable level.
  function automatic bit slot_fixed(int n);
    return (n >= 1) && (n <= 3);
  endfunction

endpackage

// File: rtl/virq_src_bank.sv
module virq_src_bank
  import virq_pkg::*;
#(
  parameter int NUM_IRQ = 43,
  parameter int PRIO_W  = 4,
  localparam int NUM_EXC = SYS_LINES + NUM_IRQ,
  localparam int NUM_W   = $clog2(NUM_EXC),
  localparam int EFF_W   = PRIO_W + 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_IRQ-1:0]              irq_pulse,
  input  logic [SYS_LINES-1:0]            sys_pulse,
  input  logic                            cfg_we,
  input  logic [2:0]                      cfg_op,
  input  logic [NUM_W-1:0]                cfg_num,
  input  logic [PRIO_W-1:0]               cfg_prio,
  input  logic                            ack_i,
  input  logic [NUM_W-1:0]                ack_num,
  input  logic                            ret_i,
  input  logic [NUM_W-1:0]                ret_num,
  output logic [NUM_EXC-1:0]              cand_o,
  output logic [NUM_EXC-1:0]              act_o,
  output logic [NUM_EXC-1:0][EFF_W-1:0]   eff_o
);

  function automatic logic [NUM_EXC-1:0] used_map();
    logic [NUM_EXC-1:0] m;
    for (int n = 0; n < NUM_EXC; n++) m[n] = (n >= SYS_LINES) || sys_slot_used(n);
    return m;
  endfunction

  localparam logic [NUM_EXC-1:0] USED    = used_map();
  localparam logic [NUM_W:0]     EXC_LIM = NUM_EXC;

  logic [NUM_EXC-1:0]             pend_q, pend_d, pend_set, pend_clr;
  logic [NUM_EXC-1:0]             act_q, act_d, act_set, act_clr;
  logic [NUM_IRQ-1:0]             en_q, en_d;
  logic [NUM_EXC-1:0][PRIO_W-1:0] prio_q, prio_d;
  logic                           pend_ce, act_ce, en_ce, prio_ce;
  logic                           cfg_hit, ack_hit, ret_hit;
  logic [NUM_W-1:0]               irq_idx;
  logic [NUM_EXC-1:0]             en_full;

  assign cfg_hit = cfg_we && ({1'b0, cfg_num} < EXC_LIM) && USED[cfg_num];
  assign ack_hit = ack_i && ({1'b0, ack_num} < EXC_LIM) && USED[ack_num];
  assign ret_hit = ret_i && ({1'b0, ret_num} < EXC_LIM);
  assign irq_idx = cfg_num - NUM_W'(SYS_LINES);

  // Next-state logic
  always_comb begin
    pend_set = {irq_pulse, sys_pulse} & USED;
    pend_clr = '0;
    act_set  = '0;
    act_clr  = '0;
    en_d     = en_q;
    prio_d   = prio_q;
    en_ce    = 1'b0;
    prio_ce  = 1'b0;
    if (cfg_hit) begin
      unique case (cfg_op)
        OP_EN_SET: if (cfg_num >= NUM_W'(SYS_LINES)) begin
          en_d[irq_idx] = 1'b1;
          en_ce         = 1'b1;
        end
        OP_EN_CLR: if (cfg_num >= NUM_W'(SYS_LINES)) begin
          en_d[irq_idx] = 1'b0;
          en_ce         = 1'b1;
        end
        OP_PEND_SET: pend_set[cfg_num] = 1'b1;
        OP_PEND_CLR: pend_clr[cfg_num] = 1'b1;
        OP_PRIO: if (!slot_fixed(int'(cfg_num))) begin
          prio_d[cfg_num] = cfg_prio;
          prio_ce         = 1'b1;
        end
        default: ;
      endcase
    end
    if (ack_hit) begin
      act_set[ack_num]  = 1'b1;
      pend_clr[ack_num] = 1'b1;
    end
    if (ret_hit) act_clr[ret_num] = 1'b1;
    pend_d  = (pend_q & ~pend_clr) | pend_set;
    act_d   = ((act_q & ~act_clr) | act_set) & USED;
    pend_ce = (|pend_set) || (|pend_clr);
    act_ce  = (|act_set) || (|act_clr);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      act_q  <= '0;
      en_q   <= '0;
      prio_q <= '0;
    end else begin
      if (pend_ce) pend_q <= pend_d;
      if (act_ce)  act_q  <= act_d;
      if (en_ce)   en_q   <= en_d;
      if (prio_ce) prio_q <= prio_d;
    end
  end

  // Effective urgency: fixed slots map to 0..2, programmable values shift up by 3.
  always_comb begin
    for (int n = 0; n < NUM_EXC; n++) begin
      if (slot_fixed(n)) eff_o[n] = EFF_W'(n - 1);
      else               eff_o[n] = EFF_W'(prio_q[n]) + EFF_W'(3);
    end
  end

  assign en_full = {en_q, {SYS_LINES{1'b1}}};
  assign cand_o  = pend_q & en_full & USED;
  assign act_o   = act_q;

  a_r8_ack_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> act_q[$past(ack_num)]);

  a_r8_ack_clears_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_hit && !pend_set[ack_num]) |=> !pend_q[$past(ack_num)]);

  a_r10_disable_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_hit && cfg_op == OP_EN_CLR && pend_q[cfg_num] && !ack_i)
      |=> pend_q[$past(cfg_num)]);

endmodule

// File: rtl/virq_arbiter.sv
module virq_arbiter #(
  parameter int N     = 59,
  parameter int EFF_W = 5,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            valid_i,
  input  logic [N-1:0][EFF_W-1:0] eff_i,
  output logic                    vld_o,
  output logic [IDX_W-1:0]        idx_o,
  output logic [EFF_W-1:0]        eff_o
);

  // Ascending scan with strict compare: the lowest index keeps a tie.
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    eff_o = '1;
    for (int n = 0; n < N; n++) begin
      if (valid_i[n] && (!vld_o || eff_i[n] < eff_o)) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(n);
        eff_o = eff_i[n];
      end
    end
  end

endmodule

// File: rtl/virq_vector.sv
module virq_vector #(
  parameter int NUM_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic              req_i,
  input  logic [NUM_W-1:0]  num_i,
  output logic [NUM_W-1:0]  num_o,
  output logic [ADDR_W-1:0] addr_o
);

  // One 4-byte table word per exception number.
  assign num_o  = req_i ? num_i : '0;
  assign addr_o = req_i ? (ADDR_W'(num_i) << 2) : '0;

endmodule

// File: rtl/vect_irq_ctrl.sv
module vect_irq_ctrl
  import virq_pkg::*;
#(
  parameter int NUM_IRQ = 43,
  parameter int PRIO_W  = 4,
  parameter int ADDR_W  = 32,
  localparam int NUM_EXC = SYS_LINES + NUM_IRQ,
  localparam int NUM_W   = $clog2(NUM_EXC),
  localparam int EFF_W   = PRIO_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   irq_pulse,
  input  logic [SYS_LINES-1:0] sys_pulse,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_op,
  input  logic [NUM_W-1:0]     cfg_num,
  input  logic [PRIO_W-1:0]    cfg_prio,
  input  logic                 ack_i,
  input  logic [NUM_W-1:0]     ack_num,
  input  logic                 ret_i,
  input  logic [NUM_W-1:0]     ret_num,
  output logic                 exc_req,
  output logic [NUM_W-1:0]     exc_num,
  output logic [ADDR_W-1:0]    exc_addr
);

  logic                           rst_meta, rst_sync;
  logic [NUM_EXC-1:0]             cand, act;
  logic [NUM_EXC-1:0][EFF_W-1:0]  eff;
  logic                           pend_vld, act_vld, preempt;
  logic [NUM_W-1:0]               pend_idx, act_idx;
  logic [EFF_W-1:0]               pend_eff, act_eff;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  virq_src_bank #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_bank (
    .clk(clk), .rst_n(rst_sync),
    .irq_pulse(irq_pulse), .sys_pulse(sys_pulse),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_num(cfg_num), .cfg_prio(cfg_prio),
    .ack_i(ack_i), .ack_num(ack_num), .ret_i(ret_i), .ret_num(ret_num),
    .cand_o(cand), .act_o(act), .eff_o(eff)
  );

  virq_arbiter #(.N(NUM_EXC), .EFF_W(EFF_W)) u_pend_arb (
    .valid_i(cand), .eff_i(eff),
    .vld_o(pend_vld), .idx_o(pend_idx), .eff_o(pend_eff)
  );

  virq_arbiter #(.N(NUM_EXC), .EFF_W(EFF_W)) u_act_arb (
    .valid_i(act), .eff_i(eff),
    .vld_o(act_vld), .idx_o(act_idx), .eff_o(act_eff)
  );

  assign preempt = pend_vld && (!act_vld || pend_eff < act_eff);
  assign exc_req = preempt;

  virq_vector #(.NUM_W(NUM_W), .ADDR_W(ADDR_W)) u_vec (
    .req_i(preempt), .num_i(pend_idx), .num_o(exc_num), .addr_o(exc_addr)
  );

  a_r3_reserved_never_offered: assert property (@(posedge clk) disable iff (!rst_sync)
    exc_req |-> !(exc_num inside {0, 7, 8, 9, 10, 13, 15}));

  a_r4_nmi_wins: assert property (@(posedge clk) disable iff (!rst_sync)
    (cand[2] && !cand[1] && (!act_vld || act_eff > EFF_W'(1)))
      |-> (exc_req && exc_num == NUM_W'(2)));

  a_r7_no_self_preempt: assert property (@(posedge clk) disable iff (!rst_sync)
    (exc_req && act_vld) |-> exc_num != act_idx);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_sync)
    !exc_req |-> (exc_num == '0 && exc_addr == '0));

endmodule

// File: tb/test_vect_irq_ctrl.sv
module test_vect_irq_ctrl;

  localparam int NI = 43;
  localparam int NW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_pulse;
  logic [15:0]   sys_pulse;
  logic          cfg_we;
  logic [2:0]    cfg_op;
  logic [NW-1:0] cfg_num;
  logic [3:0]    cfg_prio;
  logic          ack_i, ret_i;
  logic [NW-1:0] ack_num, ret_num;
  logic          exc_req;
  logic [NW-1:0] exc_num;
  logic [31:0]   exc_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  vect_irq_ctrl i_vect_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_pulse(irq_pulse), .sys_pulse(sys_pulse),
    .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_num(cfg_num), .cfg_prio(cfg_prio),
    .ack_i(ack_i), .ack_num(ack_num), .ret_i(ret_i), .ret_num(ret_num),
    .exc_req(exc_req), .exc_num(exc_num), .exc_addr(exc_addr)
  );

  function automatic bit slot_ok(int n);
    return (n >= 16 && n < 16 + NI) || (n inside {1, 2, 3, 4, 5, 6, 11, 12, 14});
  endfunction

  task automatic check(input string tag, input bit exp_req, input int exp_num);
    int en;
    logic [31:0] ea;
    en = exp_req ? exp_num : 0;
    ea = 32'(en * 4);
    checks++;
    if (exc_req !== exp_req || exc_num !== NW'(en) || exc_addr !== ea) begin
      errors++;
      $display("FAIL %s: req=%0b num=%0d addr=%0h expected req=%0b num=%0d addr=%0h",
               tag, exc_req, exc_num, exc_addr, exp_req, en, ea);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic cfg(input int op, input int num, input int prio);
    cfg_we = 1'b1; cfg_op = 3'(op); cfg_num = NW'(num); cfg_prio = 4'(prio);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic psys(input int n);
    sys_pulse[n] = 1'b1;
    @(negedge clk);
    sys_pulse = '0;
  endtask

  task automatic pirq(input int i);
    irq_pulse[i] = 1'b1;
    @(negedge clk);
    irq_pulse = '0;
  endtask

  task automatic do_ack(input int n);
    ack_i = 1'b1; ack_num = NW'(n);
    @(negedge clk);
    ack_i = 1'b0;
  endtask

  task automatic do_ret(input int n);
    ret_i = 1'b1; ret_num = NW'(n);
    @(negedge clk);
    ret_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; irq_pulse = '0; sys_pulse = '0; cfg_we = 1'b0; cfg_op = '0;
    cfg_num = '0; cfg_prio = '0; ack_i = 1'b0; ack_num = '0; ret_i = 1'b0; ret_num = '0;

    // R1: idle after reset; lines start disabled
    do_reset();
    check("R1 reset idle", 0, 0);
    pirq(0);
    check("R1 enable off after reset", 0, 0);

    // R2 R3 R8 R9: each system number alone
    for (int n = 0; n < 16; n++) begin
      do_reset();
      psys(n);
      check(slot_ok(n) ? "R2 system slot" : "R3 reserved pulse", slot_ok(n), n);
      if (!slot_ok(n)) begin
        cfg(2, n, 0);
        check("R3 reserved pend-set", 0, 0);
      end else begin
        do_ack(n);
        check("R8 ack clears pending", 0, 0);
        do_ret(n);
        check("R9 return leaves nothing", 0, 0);
      end
    end

    // R2 R8 R9: each peripheral line alone
    for (int i = 0; i < NI; i++) begin
      do_reset();
      cfg(0, 16 + i, 0);
      pirq(i);
      check("R2 peripheral slot", 1, 16 + i);
      do_ack(16 + i);
      check("R8 ack on line", 0, 0);
      do_ret(16 + i);
      check("R9 return on line", 0, 0);
    end

    // R3: numbers beyond the last line
    do_reset();
    for (int n = 16 + NI; n < 64; n++) begin
      cfg(2, n, 0);
      check("R3 out-of-range number", 0, 0);
    end

    // R5 R6: full priority sweep on lines 5 (num 21) and 30 (num 46)
    for (int pa = 0; pa < 16; pa++) begin
      for (int pb = 0; pb < 16; pb++) begin
        do_reset();
        cfg(0, 21, 0); cfg(0, 46, 0);
        cfg(4, 21, pa); cfg(4, 46, pb);
        irq_pulse[5] = 1'b1; irq_pulse[30] = 1'b1;
        @(negedge clk);
        irq_pulse = '0;
        check(pa == pb ? "R6 tie lower number" : "R5 lower value wins", 1, (pb < pa) ? 46 : 21);
      end
    end

    // R5 R6: system programmable against peripheral
    do_reset();
    cfg(0, 16, 0);
    pirq(0); psys(4);
    check("R6 tie system vs line", 1, 4);
    cfg(4, 4, 7); cfg(4, 16, 6);
    check("R5 system vs line", 1, 16);

    // R4 R7 R9: fixed ladder
    do_reset();
    cfg(0, 16, 0);
    cfg(4, 3, 15);
    pirq(0); psys(3);
    check("R4 fault over level 0", 1, 3);
    psys(2);
    check("R4 nmi over fault", 1, 2);
    psys(1);
    check("R4 reset over nmi", 1, 1);
    do_ack(1);
    check("R7 nothing beats active reset", 0, 0);
    do_ret(1);
    check("R9 nmi after return", 1, 2);

    // R7: strict preemption and nesting
    do_reset();
    cfg(0, 17, 0); cfg(0, 18, 0); cfg(0, 19, 0);
    cfg(4, 17, 5); cfg(4, 18, 5); cfg(4, 19, 4);
    pirq(1);
    check("R7 idle core takes line", 1, 17);
    do_ack(17);
    pirq(2);
    check("R7 equal stays pending", 0, 0);
    pirq(3);
    check("R7 strictly higher preempts", 1, 19);
    do_ack(19);
    check("R7 nested active", 0, 0);
    do_ret(19);
    check("R7 equal still blocked", 0, 0);
    do_ret(17);
    check("R9 release after return", 1, 18);

    // R10 R12: disable keeps pending, pend clear and set by write
    do_reset();
    cfg(0, 23, 0); cfg(4, 23, 2);
    pirq(7);
    check("R12 pulse pends", 1, 23);
    cfg(1, 23, 0);
    check("R10 disabled not offered", 0, 0);
    cfg(0, 23, 0);
    check("R10 pending kept", 1, 23);
    cfg(3, 23, 0);
    check("R12 pend clear", 0, 0);
    cfg(2, 23, 0);
    check("R12 pend set write", 1, 23);
    cfg(5, 23, 0);
    check("R12 unused op code", 1, 23);

    // R11: system exceptions ignore enable-clear
    do_reset();
    cfg(1, 2, 0);
    psys(2);
    check("R11 nmi unmaskable", 1, 2);
    do_reset();
    cfg(1, 4, 0);
    psys(4);
    check("R11 system no enable", 1, 4);

    finish_run();
  end

endmodule